// File: doc/BRIEF.md
# DSD-over-PCM Marker Detector

This block sits on a stereo PCM sample path and decides, frame by frame, whether the stream is ordinary PCM audio or a DSD bitstream packed into PCM words. Each frame is one 32-bit left sample and one 32-bit right sample, qualified by a single-cycle frame strobe. The top byte of each sample is the marker field. In a packed DSD stream that byte alternates between two fixed codes from one frame to the next.

The detector keeps an expected marker and a run counter of consecutive matching frames. It switches to DSD mode only after a long unbroken run. Once in DSD mode it accepts a single repeated marker as a tolerable glitch, and it falls back to PCM on any other disturbance. The resulting flag is meant for downstream logic, for example to mute a digital transmitter. A one-clock pulse marks every mode change.

Top module: `dop_mode_detect`

## Requirements
- R1: A synchronous reset puts the block in PCM mode (`dsd_mode_o` = 0), holds `mode_chg_o` low and sets the expected marker to 0x05.
- R2: The marker field of a sample is bits 31:24. A frame matches only when the left and the right marker fields both equal the expected marker. Bits 23:0 have no effect.
- R3: After every matching frame the expected marker is XORed with 0xFF, so a matching stream alternates 0x05, 0xFA, 0x05, and so on.
- R4: In PCM mode, the 32nd consecutive matching frame switches the block to DSD mode. 31 consecutive matches leave it in PCM.
- R5: A non-matching frame clears the run of consecutive matches, so a new full run of 32 is needed to enter DSD mode.
- R6: In DSD mode, a non-matching frame whose left marker field equals the expected marker XOR 0xFF (a repeated previous marker) keeps the block in DSD mode and leaves the expected marker unchanged.
- R7: In DSD mode, any other non-matching frame returns the block to PCM mode. This includes a frame whose left field matches but whose right field does not.
- R8: When `frame_vld_i` is low, the inputs are ignored and the mode, the expected marker and the run count all hold.
- R9: `mode_chg_o` is high for exactly one clock, in the cycle after the frame that changed the mode, on every PCM-to-DSD and DSD-to-PCM transition, and is low otherwise.
- R10: The mode flag and the change pulse are registered. They update on the clock edge that samples the deciding frame.
- R11: After entry to DSD mode the expected marker keeps alternating, so a continuing valid stream stays in DSD mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| frame_vld_i | input | 1 | Frame strobe; left_i/right_i are evaluated when high |
| left_i | input | 32 | Left sample; marker field in bits 31:24 |
| right_i | input | 32 | Right sample; marker field in bits 31:24 |
| dsd_mode_o | output | 1 | 1 = DSD payload detected, 0 = PCM |
| mode_chg_o | output | 1 | One-clock pulse on each mode transition |

## Verification
The bound checker checks these properties on every cycle:
- the mode flag never moves without a frame strobe;
- the change pulse coincides exactly with a flip of the flag;
- entry to DSD mode follows a frame whose two marker fields agree;
- a frame carrying one of the two marker codes in both fields never drops DSD mode.

Some behaviour needs a known history and can only be shown by the bench's scenarios:
- the exact threshold of 32 and the 31-frame near miss;
- the restart of the run after a broken frame;
- the tolerance of a repeated marker, which depends on the internal expected value;
- exit when only the right field is wrong.

// File: rtl/dop_det_pkg.sv
package dop_det_pkg;

    typedef enum logic {
        MODE_PCM = 1'b0,
        MODE_DSD = 1'b1
    } mode_e;

    localparam logic [7:0] MARK_FIRST = 8'h05;
    localparam logic [7:0] MARK_FLIP  = 8'hFF;

endpackage

// File: rtl/dop_field_cmp.sv
module dop_field_cmp #(
    parameter int SAMPLE_W = 32,
    parameter int MARK_W   = 8
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [MARK_W-1:0]   expect_i,
    output logic                eq_o,
    output logic                eq_inv_o
);
    logic [MARK_W-1:0] field;

    always_comb begin
        field    = sample_i[SAMPLE_W-1 -: MARK_W];
        eq_o     = (field == expect_i);
        eq_inv_o = (field == ~expect_i);
    end
endmodule

// File: rtl/dop_run_cnt.sv
module dop_run_cnt #(
    parameter int THRESH = 32
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    input  logic clear_i,
    output logic hit_o
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i && (cnt_q < LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
        hit_o = step_i && (cnt_q >= LAST);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dop_mode_detect.sv
module dop_mode_detect #(
    parameter int SAMPLE_W = 32,
    parameter int MARK_W   = 8,
    parameter int THRESH   = 32
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                frame_vld_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                dsd_mode_o,
    output logic                mode_chg_o
);
    import dop_det_pkg::*;

    localparam int NCH = 2;

    typedef struct packed {
        mode_e             mode;
        logic [MARK_W-1:0] expect_m;
        logic              chg;
    } state_t;

    state_t st_d, st_q;

    logic [SAMPLE_W-1:0] chan_smp [NCH];
    logic [NCH-1:0]      ch_eq, ch_eq_inv;
    logic                frame_match, repeat_ok, run_hit;
    logic                cnt_step, cnt_clear;

    assign chan_smp[0] = left_i;
    assign chan_smp[1] = right_i;

    for (genvar c = 0; c < NCH; c++) begin : g_cmp
        dop_field_cmp #(
            .SAMPLE_W(SAMPLE_W),
            .MARK_W  (MARK_W)
        ) u_cmp (
            .sample_i(chan_smp[c]),
            .expect_i(st_q.expect_m),
            .eq_o    (ch_eq[c]),
            .eq_inv_o(ch_eq_inv[c])
        );
    end

    always_comb begin
        frame_match = &ch_eq;
        repeat_ok   = ch_eq_inv[0];
        cnt_step    = frame_vld_i && frame_match;
        cnt_clear   = frame_vld_i &&
                      (!frame_match || (run_hit && st_q.mode == MODE_PCM));
    end

    dop_run_cnt #(
        .THRESH(THRESH)
    ) u_run (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .step_i (cnt_step),
        .clear_i(cnt_clear),
        .hit_o  (run_hit)
    );

    always_comb begin
        st_d = st_q;
        if (frame_vld_i) begin
            if (frame_match) begin
                st_d.expect_m = st_q.expect_m ^ MARK_W'(MARK_FLIP);
                if (st_q.mode == MODE_PCM && run_hit) begin
                    st_d.mode = MODE_DSD;
                end
            end else if (st_q.mode == MODE_DSD && !repeat_ok) begin
                st_d.mode = MODE_PCM;
            end
        end
        st_d.chg = (st_d.mode != st_q.mode);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.mode     <= MODE_PCM;
            st_q.expect_m <= MARK_W'(MARK_FIRST);
            st_q.chg      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dsd_mode_o = (st_q.mode == MODE_DSD);
    assign mode_chg_o = st_q.chg;
endmodule

// File: rtl/dop_mode_detect_chk.sv
module dop_mode_detect_chk #(
    parameter int SAMPLE_W = 32,
    parameter int MARK_W   = 8
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                frame_vld_i,
    input logic [SAMPLE_W-1:0] left_i,
    input logic [SAMPLE_W-1:0] right_i,
    input logic                dsd_mode_o,
    input logic                mode_chg_o
);
    logic [MARK_W-1:0] lf, rf;
    assign lf = left_i[SAMPLE_W-1 -: MARK_W];
    assign rf = right_i[SAMPLE_W-1 -: MARK_W];

    // R8
    hold_without_frame_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_vld_i |=> $stable(dsd_mode_o));

    // R9
    pulse_on_flip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_chg_o |-> (dsd_mode_o != $past(dsd_mode_o)));

    // R9
    flip_has_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dsd_mode_o != $past(dsd_mode_o)) |-> mode_chg_o);

    // R2
    entry_needs_pair_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(dsd_mode_o) |-> $past(frame_vld_i && (lf == rf)));

    // R6
    marker_keeps_dsd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dsd_mode_o && frame_vld_i && (lf == rf) &&
         ((lf == 8'h05) || (lf == 8'hFA))) |=> dsd_mode_o);

    // R7
    exit_needs_frame_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(dsd_mode_o) |-> $past(frame_vld_i));
endmodule

bind dop_mode_detect dop_mode_detect_chk #(
    .SAMPLE_W(SAMPLE_W),
    .MARK_W  (MARK_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .frame_vld_i(frame_vld_i),
    .left_i     (left_i),
    .right_i    (right_i),
    .dsd_mode_o (dsd_mode_o),
    .mode_chg_o (mode_chg_o)
);

// File: tb/tb_dop_mode_detect.sv
module tb_dop_mode_detect;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld = 1'b0;
    logic [31:0] lft = '0;
    logic [31:0] rgt = '0;
    logic        dsd, chg;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_m;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    dop_mode_detect dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .frame_vld_i(vld),
        .left_i     (lft),
        .right_i    (rgt),
        .dsd_mode_o (dsd),
        .mode_chg_o (chg)
    );

    task automatic check(input string req, input logic act_mode, input logic act_chg,
                         input logic want_mode, input logic want_chg);
        checks++;
        if (act_mode !== want_mode || act_chg !== want_chg) begin
            errors++;
            $display("FAIL %s: mode=%0b chg=%0b expected mode=%0b chg=%0b",
                     req, act_mode, act_chg, want_mode, want_chg);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_m = 8'h05;
    endtask

    task automatic frame(input logic [7:0] lm, input logic [7:0] rm);
        lft = {lm, 24'h5A3C71};
        rgt = {rm, 24'h0F1E2D};
        vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            frame(exp_m, exp_m);
            exp_m = exp_m ^ 8'hFF;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset state", dsd, chg, 1'b0, 1'b0);
    endtask

    task automatic t_enter();
        do_reset();
        run(31);
        check("R4 31 matches stay PCM", dsd, chg, 1'b0, 1'b0);
        run(1);
        check("R4 R3 32nd match enters DSD", dsd, chg, 1'b1, 1'b1);
        @(negedge clk);
        check("R9 pulse one cycle", dsd, chg, 1'b1, 1'b0);
    endtask

    task automatic t_continue();
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < 40; i++) begin
            run(1);
            if (dsd !== 1'b1 || chg !== 1'b0) bad = 1'b1;
        end
        check("R11 alternation keeps DSD", bad, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_tolerate();
        frame(exp_m ^ 8'hFF, exp_m ^ 8'hFF);
        check("R6 repeated marker tolerated", dsd, chg, 1'b1, 1'b0);
        run(1);
        check("R6 expected unchanged after repeat", dsd, chg, 1'b1, 1'b0);
    endtask

    task automatic t_hold_dsd();
        lft = 32'h00000000; rgt = 32'h11000000;
        repeat (5) @(negedge clk);
        check("R8 idle junk ignored in DSD", dsd, chg, 1'b1, 1'b0);
    endtask

    task automatic t_exit_left();
        frame(8'h00, exp_m);
        check("R7 R9 bad left exits DSD", dsd, chg, 1'b0, 1'b1);
        @(negedge clk);
        check("R9 exit pulse one cycle", dsd, chg, 1'b0, 1'b0);
    endtask

    task automatic t_exit_right();
        do_reset();
        run(32);
        check("R10 entry for right test", dsd, chg, 1'b1, 1'b1);
        frame(exp_m, 8'h77);
        check("R7 bad right exits DSD", dsd, chg, 1'b0, 1'b1);
    endtask

    task automatic t_right_needed();
        do_reset();
        run(31);
        frame(exp_m, exp_m ^ 8'hFF);
        check("R2 right mismatch blocks entry", dsd, chg, 1'b0, 1'b0);
    endtask

    task automatic t_break();
        do_reset();
        run(20);
        frame(8'h00, 8'h00);
        run(31);
        check("R5 run restarts after mismatch", dsd, chg, 1'b0, 1'b0);
        run(1);
        check("R5 full new run enters", dsd, chg, 1'b1, 1'b1);
    endtask

    task automatic t_hold_pcm();
        do_reset();
        run(10);
        lft = 32'h00000000; rgt = 32'h00000000;
        repeat (6) @(negedge clk);
        run(21);
        check("R8 idle cycles keep count", dsd, chg, 1'b0, 1'b0);
        run(1);
        check("R8 count resumed to 32", dsd, chg, 1'b1, 1'b1);
    endtask

    task automatic t_odd_start();
        do_reset();
        frame(8'hFA, 8'hFA);
        run(31);
        check("R3 first FA frame does not count", dsd, chg, 1'b0, 1'b0);
        run(1);
        check("R3 entry from 0x05 start", dsd, chg, 1'b1, 1'b1);
    endtask

    initial begin
        t_reset();
        t_enter();
        t_continue();
        t_tolerate();
        t_hold_dsd();
        t_exit_left();
        t_exit_right();
        t_right_needed();
        t_break();
        t_hold_pcm();
        t_odd_start();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule